// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block performs hardware flow control for a single asynchronous serial channel. On the receive side it watches the fill level of the receive FIFO and drives the active-low request-to-send line: RTS is withdrawn when the FIFO has filled to a programmed stop level. It is raised again only after the FIFO has drained to a separate, lower restart level, so the line does not chatter around one level. Both levels come from one 8-bit threshold register and are counted in units of four bytes.

On the transmit side the block stands between the transmitter's "character ready" request and the serializer. When automatic CTS is on, a new character may start only while the synchronized, active-low clear-to-send input is active. A character that has already started always runs to completion. The two automatic functions are switched on separately by bits 7 (CTS) and 6 (RTS) of a control field. With automatic RTS off, RTS follows a manual request bit.

The receive-side machine has three states. RTS_MANUAL goes to RTS_FLOW or RTS_STOP when automatic RTS is enabled. RTS_FLOW goes to RTS_STOP when the stop level is reached. RTS_STOP goes to RTS_FLOW when the FIFO has drained. Both RTS_FLOW and RTS_STOP return to RTS_MANUAL when automatic RTS is disabled. The transmit-side machine also has three states. TX_IDLE goes to TX_BUSY on a permitted request, or to TX_WAIT on a request that CTS blocks. TX_WAIT goes to TX_BUSY when CTS becomes active, or back to TX_IDLE when the request is withdrawn. TX_BUSY goes to TX_IDLE on the character-done strobe. Storage and serialization are handled elsewhere.

Top module: `uart_hw_flow_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rts_n` is 1, `tx_go` is 0, and the CTS synchronizer holds the inactive value.
- R2: `flow_cfg[6]` enables automatic RTS and `flow_cfg[7]` enables automatic CTS. Each works without the other. While automatic RTS is on, `man_rts` has no effect on `rts_n`.
- R3: With automatic RTS off, `rts_n` equals the inverse of `man_rts` one clock after it is sampled.
- R4: The stop level is `thr_cfg[3:0]` times 4 bytes. With automatic RTS on, a sampled `rx_level` at or above the stop level drives `rts_n` to 1 one clock later.
- R5: The restart level is `thr_cfg[7:4]` times 4 bytes. Once stopped, `rts_n` stays 1 until `rx_level` is at or below the restart level, and returns to 0 one clock after that sample.
- R6: When the restart level is not below the stop level, RTS reasserts as soon as `rx_level` is below the stop level, so RTS switches at a single level.
- R7: A stop field of 15 (60 bytes) leaves free entries in a 64-entry FIFO for one late character. Levels above the stop level keep `rts_n` at 1. A stop field of 0 keeps `rts_n` at 1 for as long as automatic RTS is on.
- R8: On entry into automatic RTS, the first `rts_n` value is set by comparing the current level against the stop level.
- R9: With automatic CTS on, no `tx_go` is issued while the synchronized CTS is inactive. Once `cts_n` is sampled low, `tx_go` rises three clocks later (two synchronizer stages plus the output register).
- R10: `tx_go` is a one-clock pulse per character. No further pulse is issued until `tx_char_done` is sampled, and the next pulse comes at the earliest one clock after that.
- R11: CTS going inactive while a character is in flight does not cancel that character. It holds off only the following start.
- R12: With automatic CTS off, a request sampled in TX_IDLE yields `tx_go` one clock later, whatever the value of `cts_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flow_cfg | input | 2 | Bits [7:6] of the control field: 7 enables automatic CTS, 6 enables automatic RTS |
| man_rts | input | 1 | Manual RTS request; 1 drives `rts_n` low while automatic RTS is off |
| thr_cfg | input | 8 | [3:0] stop level / 4, [7:4] restart level / 4 |
| rx_level | input | LVL_W (7) | Receive FIFO fill level in bytes |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| tx_start_req | input | 1 | Transmitter holds a character and asks to start it |
| tx_char_done | input | 1 | One-clock strobe at the end of the current character |
| rts_n | output | 1 | Request to send, active low, registered |
| tx_go | output | 1 | One-clock permit to start the next character, registered |

## Verification
Every result is registered, so a change to `rx_level`, `thr_cfg`, `man_rts` or `flow_cfg[6]` shows on `rts_n` one clock later. A request or done strobe shows on `tx_go` one clock later, while a change on `cts_n` needs three clocks. The bench drives inputs just after the falling edge and samples just before the next falling edge. Its reference model steps once per rising edge and keeps its own two-entry CTS history, so every comparison lands in the cycle the result is due. Directed checks on latency count the exact number of edges, with one check one edge too early and one on the due edge.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

    // Control field bit positions (decoded by the register block next door)
    localparam int AUTO_CTS_BIT = 7;
    localparam int AUTO_RTS_BIT = 6;

    // Threshold register field layout
    localparam int THR_FIELD_W = 4;

    typedef enum logic [1:0] {
        RTS_MANUAL = 2'd0,
        RTS_FLOW   = 2'd1,
        RTS_STOP   = 2'd2
    } rts_state_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_WAIT = 2'd1,
        TX_BUSY = 2'd2
    } tx_state_e;

endpackage

// File: rtl/hfc_sync.sv
module hfc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/hfc_thr_decode.sv
module hfc_thr_decode
    import hfc_pkg::*;
#(
    parameter int LVL_W     = 7,
    parameter int THR_SCALE = 4
) (
    input  logic [7:0]       thr_cfg,
    input  logic [LVL_W-1:0] level,
    output logic             at_halt,
    output logic             drained
);

    localparam int SCALED_W = THR_FIELD_W + $clog2(THR_SCALE) + 1;
    localparam int CMP_W    = (LVL_W > SCALED_W) ? LVL_W : SCALED_W;

    logic [CMP_W-1:0] halt_lvl;
    logic [CMP_W-1:0] resume_lvl;
    logic [CMP_W-1:0] lvl_ext;
    logic             resume_usable;

    always_comb begin
        halt_lvl      = CMP_W'(thr_cfg[THR_FIELD_W-1:0]) * CMP_W'(THR_SCALE);
        resume_lvl    = CMP_W'(thr_cfg[7:THR_FIELD_W])   * CMP_W'(THR_SCALE);
        lvl_ext       = CMP_W'(level);
        resume_usable = (resume_lvl < halt_lvl);
        at_halt       = (lvl_ext >= halt_lvl);
        // A restart level at or above the stop level collapses to the stop level
        if (resume_usable) drained = (lvl_ext <= resume_lvl);
        else               drained = (lvl_ext <  halt_lvl);
    end

endmodule

// File: rtl/hfc_rts_fsm.sv
module hfc_rts_fsm
    import hfc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic man_rts,
    input  logic at_halt,
    input  logic drained,
    output logic rts_n
);

    rts_state_e state_q;
    rts_state_e state_nxt;
    logic       rts_n_q;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            RTS_MANUAL: begin
                if (auto_en) state_nxt = at_halt ? RTS_STOP : RTS_FLOW;
            end
            RTS_FLOW: begin
                if (!auto_en)     state_nxt = RTS_MANUAL;
                else if (at_halt) state_nxt = RTS_STOP;
            end
            RTS_STOP: begin
                if (!auto_en)     state_nxt = RTS_MANUAL;
                else if (drained) state_nxt = RTS_FLOW;
            end
            default: state_nxt = RTS_MANUAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RTS_MANUAL;
        else     state_q <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rts_n_q <= 1'b1;
        end else begin
            unique case (state_nxt)
                RTS_FLOW:   rts_n_q <= 1'b0;
                RTS_STOP:   rts_n_q <= 1'b1;
                RTS_MANUAL: rts_n_q <= ~man_rts;
                default:    rts_n_q <= 1'b1;
            endcase
        end
    end

    assign rts_n = rts_n_q;

endmodule

// File: rtl/hfc_tx_gate.sv
module hfc_tx_gate
    import hfc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic cts_ok,
    input  logic start_req,
    input  logic char_done,
    output logic tx_go
);

    tx_state_e state_q;
    tx_state_e state_nxt;
    logic      go_q;
    logic      may_start;

    assign may_start = !auto_en || cts_ok;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (start_req) state_nxt = may_start ? TX_BUSY : TX_WAIT;
            end
            TX_WAIT: begin
                if (!start_req)     state_nxt = TX_IDLE;
                else if (may_start) state_nxt = TX_BUSY;
            end
            TX_BUSY: begin
                if (char_done) state_nxt = TX_IDLE;
            end
            default: state_nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) go_q <= 1'b0;
        else     go_q <= (state_q != TX_BUSY) && (state_nxt == TX_BUSY);
    end

    assign tx_go = go_q;

endmodule

// File: rtl/uart_hw_flow_ctrl.sv
module uart_hw_flow_ctrl
    import hfc_pkg::*;
#(
    parameter  int FIFO_DEPTH = 64,
    parameter  int THR_SCALE  = 4,
    parameter  int CTS_SYNC   = 2,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:6]       flow_cfg,
    input  logic             man_rts,
    input  logic [7:0]       thr_cfg,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             cts_n,
    input  logic             tx_start_req,
    input  logic             tx_char_done,
    output logic             rts_n,
    output logic             tx_go
);

    logic cts_n_sync;
    logic at_halt;
    logic drained;

    hfc_sync #(
        .STAGES  (CTS_SYNC),
        .RST_VAL (1'b1)
    ) u_cts_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (cts_n),
        .q_out (cts_n_sync)
    );

    hfc_thr_decode #(
        .LVL_W     (LVL_W),
        .THR_SCALE (THR_SCALE)
    ) u_thr (
        .thr_cfg (thr_cfg),
        .level   (rx_level),
        .at_halt (at_halt),
        .drained (drained)
    );

    hfc_rts_fsm u_rts (
        .clk     (clk),
        .rst     (rst),
        .auto_en (flow_cfg[AUTO_RTS_BIT]),
        .man_rts (man_rts),
        .at_halt (at_halt),
        .drained (drained),
        .rts_n   (rts_n)
    );

    hfc_tx_gate u_tx (
        .clk       (clk),
        .rst       (rst),
        .auto_en   (flow_cfg[AUTO_CTS_BIT]),
        .cts_ok    (!cts_n_sync),
        .start_req (tx_start_req),
        .char_done (tx_char_done),
        .tx_go     (tx_go)
    );

endmodule

// File: rtl/uart_hw_flow_ctrl_chk.sv
module uart_hw_flow_ctrl_chk #(
    parameter int LVL_W     = 7,
    parameter int THR_SCALE = 4,
    parameter int CTS_SYNC  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [7:6]       flow_cfg,
    input logic             man_rts,
    input logic [7:0]       thr_cfg,
    input logic [LVL_W-1:0] rx_level,
    input logic             cts_n,
    input logic             rts_n,
    input logic             tx_go
);

    function automatic int stop_bytes(input logic [7:0] t);
        return int'(t[3:0]) * THR_SCALE;
    endfunction

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (rts_n && !tx_go));  // R1

    AST_MANUAL_RTS: assert property (@(posedge clk) disable iff (rst)
        !flow_cfg[6] |=> (rts_n == !$past(man_rts)));  // R3

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (flow_cfg[6] && (int'(rx_level) >= stop_bytes(thr_cfg))) |=> rts_n);  // R4

    AST_REASSERT_BELOW_STOP: assert property (@(posedge clk) disable iff (rst)
        ($fell(rts_n) && $past(flow_cfg[6])) |-> (int'($past(rx_level)) < stop_bytes($past(thr_cfg))));  // R5

    AST_CTS_GATES_START: assert property (@(posedge clk) disable iff (rst)
        (tx_go && $past(flow_cfg[7])) |-> !$past(cts_n, CTS_SYNC + 1));  // R9

    AST_GO_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_go |=> !tx_go);  // R10

endmodule

bind uart_hw_flow_ctrl uart_hw_flow_ctrl_chk #(
    .LVL_W     (LVL_W),
    .THR_SCALE (THR_SCALE),
    .CTS_SYNC  (CTS_SYNC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .flow_cfg (flow_cfg),
    .man_rts  (man_rts),
    .thr_cfg  (thr_cfg),
    .rx_level (rx_level),
    .cts_n    (cts_n),
    .rts_n    (rts_n),
    .tx_go    (tx_go)
);

// File: tb/uart_hw_flow_ctrl_bench.sv
module uart_hw_flow_ctrl_bench;

    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:6]    flow_cfg = 2'b00;
    logic          man_rts = 1'b0;
    logic [7:0]    thr_cfg = 8'h00;
    logic [LW-1:0] rx_level = '0;
    logic          cts_n = 1'b1;
    logic          tx_start_req = 1'b0;
    logic          tx_char_done = 1'b0;
    logic          rts_n;
    logic          tx_go;

    int    tests = 0;
    int    fails = 0;
    int    cyc   = 0;
    string cur_req = "R1";

    // reference model state
    bit m_rts_n = 1'b1;
    bit m_go    = 1'b0;
    bit m_busy  = 1'b0;
    bit m_auto  = 1'b0;
    bit m_stop  = 1'b0;
    bit cts_hist[$];

    always #5 clk = ~clk;

    uart_hw_flow_ctrl u_uart_hw_flow_ctrl (
        .clk          (clk),
        .rst          (rst),
        .flow_cfg     (flow_cfg),
        .man_rts      (man_rts),
        .thr_cfg      (thr_cfg),
        .rx_level     (rx_level),
        .cts_n        (cts_n),
        .tx_start_req (tx_start_req),
        .tx_char_done (tx_char_done),
        .rts_n        (rts_n),
        .tx_go        (tx_go)
    );

    // behavioural reference, stepped once per rising edge
    always @(posedge clk) begin
        int  stop_l;
        int  res_l;
        int  lv;
        bit  cts_seen_low;
        stop_l = int'(thr_cfg[3:0]) * 4;
        res_l  = int'(thr_cfg[7:4]) * 4;
        lv     = int'(rx_level);
        if (rst) begin
            cts_hist = '{1'b1, 1'b1};
            m_rts_n = 1'b1; m_go = 1'b0; m_busy = 1'b0; m_auto = 1'b0; m_stop = 1'b0;
        end else begin
            cts_seen_low = (cts_hist[0] == 1'b0);
            void'(cts_hist.pop_front());
            cts_hist.push_back(cts_n);
            // transmit side
            if (m_busy) begin
                m_go = 1'b0;
                if (tx_char_done) m_busy = 1'b0;
            end else if (tx_start_req && (!flow_cfg[7] || cts_seen_low)) begin
                m_go = 1'b1; m_busy = 1'b1;
            end else begin
                m_go = 1'b0;
            end
            // receive side
            if (!flow_cfg[6]) begin
                m_auto = 1'b0;
                m_rts_n = !man_rts;
            end else begin
                if (!m_auto)     m_stop = (lv >= stop_l);
                else if (!m_stop) m_stop = (lv >= stop_l);
                else if (res_l < stop_l) m_stop = !(lv <= res_l);
                else             m_stop = !(lv < stop_l);
                m_auto  = 1'b1;
                m_rts_n = m_stop;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cyc > 0) begin
            tests++;
            if (rts_n !== m_rts_n || tx_go !== m_go) begin
                fails++;
                $display("FAIL %s cycle %0d: rts_n=%b tx_go=%b expected rts_n=%b tx_go=%b",
                         cur_req, cyc, rts_n, tx_go, m_rts_n, m_go);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic nx(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(logic got, logic exp, string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic lvl_rts(int lv, logic exp, string tag);
        rx_level = LW'(lv);
        nx();
        chk(rts_n, exp, tag);
    endtask

    initial begin
        logic [15:0] lfsr;
        nx(3);
        chk(rts_n, 1'b1, "R1 rts_n in reset");
        chk(tx_go, 1'b0, "R1 tx_go in reset");
        rst = 1'b0;
        nx();
        chk(rts_n, 1'b1, "R1 rts_n after reset");

        cur_req = "R3";
        man_rts = 1'b1; nx(); chk(rts_n, 1'b0, "R3 manual on");
        man_rts = 1'b0; nx(); chk(rts_n, 1'b1, "R3 manual off");

        cur_req = "R5";
        thr_cfg = 8'h24; rx_level = 7'd20; man_rts = 1'b1; flow_cfg = 2'b01;
        nx(); chk(rts_n, 1'b1, "R8 entry above stop, R2 man_rts ignored");
        lvl_rts(10, 1'b1, "R5 above restart stays stopped");
        lvl_rts(9,  1'b1, "R5 one above restart");
        lvl_rts(8,  1'b0, "R5 at restart reasserts");
        lvl_rts(15, 1'b0, "R4 below stop");
        lvl_rts(16, 1'b1, "R4 at stop");
        lvl_rts(12, 1'b1, "R5 hysteresis band");
        lvl_rts(7,  1'b0, "R5 below restart");

        cur_req = "R6";
        thr_cfg = 8'h44;
        lvl_rts(16, 1'b1, "R6 equal levels stop");
        lvl_rts(15, 1'b0, "R6 equal levels restart");
        thr_cfg = 8'h94;
        lvl_rts(16, 1'b1, "R6 restart above stop");
        lvl_rts(15, 1'b0, "R6 restart above stop reasserts");

        cur_req = "R7";
        thr_cfg = 8'h0F;
        lvl_rts(59, 1'b0, "R7 below 60");
        lvl_rts(60, 1'b1, "R7 at 60");
        lvl_rts(61, 1'b1, "R7 late character");
        lvl_rts(64, 1'b1, "R7 full");
        thr_cfg = 8'h00;
        lvl_rts(0, 1'b1, "R7 stop field zero");

        cur_req = "R2";
        flow_cfg = 2'b00; man_rts = 1'b1;
        nx(); chk(rts_n, 1'b0, "R2 auto RTS off returns to manual");

        cur_req = "R12";
        cts_n = 1'b1; tx_start_req = 1'b1;
        nx(); chk(tx_go, 1'b1, "R12 start without CTS gating");
        cur_req = "R10";
        nx(); chk(tx_go, 1'b0, "R10 single pulse");
        nx(3); chk(tx_go, 1'b0, "R10 no second start while busy");
        tx_char_done = 1'b1; nx(); tx_char_done = 1'b0;
        chk(tx_go, 1'b0, "R10 no pulse on done edge");
        nx(); chk(tx_go, 1'b1, "R10 next start one clock after done");

        cur_req = "R9";
        flow_cfg = 2'b10;
        tx_char_done = 1'b1; nx(); tx_char_done = 1'b0;
        nx(5); chk(tx_go, 1'b0, "R9 held while CTS inactive");
        chk(rts_n, 1'b0, "R2 auto CTS alone keeps manual RTS");
        cts_n = 1'b0;
        nx(2); chk(tx_go, 1'b0, "R9 not before three clocks");
        nx();  chk(tx_go, 1'b1, "R9 start three clocks after CTS");

        cur_req = "R11";
        cts_n = 1'b1;
        nx(3); chk(tx_go, 1'b0, "R11 in flight, no new start");
        tx_char_done = 1'b1; nx(); tx_char_done = 1'b0;
        nx(4); chk(tx_go, 1'b0, "R11 next start held");
        cts_n = 1'b0;
        nx(3); chk(tx_go, 1'b1, "R11 resumes after CTS");
        tx_char_done = 1'b1; nx(); tx_char_done = 1'b0;

        cur_req = "R4 R5 R9 R10 mixed";
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'd0) rx_level = LW'(lfsr[15:9] % 65);
            else if (lfsr[1] && rx_level < 7'd64) rx_level = rx_level + 7'd1;
            else if (rx_level > 7'd0) rx_level = rx_level - 7'd1;
            if (lfsr[7:4] == 4'd3) cts_n = ~cts_n;
            tx_start_req = lfsr[8] | lfsr[2];
            tx_char_done = (lfsr[11:9] == 3'd5);
            man_rts      = lfsr[12];
            if (lfsr[15:10] == 6'd7) flow_cfg = lfsr[6:5];
            if (lfsr[15:10] == 6'd9) thr_cfg  = {lfsr[3:0], lfsr[9:6]};
            nx();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule